// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synchronous SRAM core with no bus turnaround. Every access, whether a read or a write, uses the data bus exactly two clock cycles after the cycle that issued it. A read returns its word in a registered output two edges after the command. A write takes its data from the input bus two edges after the command, and the array is updated one edge later. Because reads and writes have the same latency on the bus, they can be interleaved in any order with no idle cycles. A small command pipeline carries the valid flag, the direction, the address and the byte enables from the issue cycle to the data cycle.

An external burst sequencer supplies the address on every cycle. A load cycle starts a new read burst or write burst, or it deselects the core. A cycle without a load continues the current burst in the same direction at the supplied address. A small state machine tracks the current burst. Its states are IDLE, READ_BURST and WRITE_BURST. Its transitions are start_read (load with select, read), start_write (load with select, write), deselect (load without select) and continue (no load, state kept).

Each word is split into 9-bit lanes. Every lane has its own active-low write enable. A hold input freezes the whole core for as many cycles as it stays high. The output-enable input gates the data-drive flag without a clock. If a read falls two cycles after a write to the same address, the write has not yet reached the array, so the read takes that data from a forwarding path.

Top module: `lw_sram`

## Requirements
- R1: After reset is released, `rdrive` is low, and no read or write takes place until a new command is issued.
- R2: A read issued on cycle N (`load`=1, `sel`=1, `wr`=0, `hold`=0) sets `rdrive` high and places the word at `addr` on `rdata` after rising edge N+2.
- R3: A write issued on cycle N takes `wdata` at rising edge N+2 and never drives `rdrive` for that slot. Later reads return the stored data.
- R4: `bwe_n[i]`=0 enables writing of data bits [9i+8:9i]. Lanes whose enable bit is 1 keep their previous contents.
- R5: `bwe_n` has no effect on reads. A read returns the full word and leaves the array unchanged.
- R6: With `load`=0, the core continues the last burst in the same direction at the `addr` supplied on that cycle, and `wr` is ignored. After a deselect, cycles with `load`=0 perform no access.
- R7: A deselect (`load`=1, `sel`=0) issued on cycle N leaves `rdrive` low after edge N+2.
- R8: `oe_n`=1 forces `rdrive` low at once, without waiting for a clock edge. When `oe_n` returns to 0, the pipeline's drive state reappears.
- R9: While `hold` is high, the command pipeline, the array, `rdata` and the drive state stay unchanged. Held cycles issue nothing and do not count toward the two-cycle latency.
- R10: A read whose data cycle directly follows the data cycle of a write to the same address returns the new data on the enabled lanes, even though the array has not been updated yet.
- R11: Reads and writes can alternate on consecutive cycles with no idle slot. Between reads, `rdata` keeps the last read word and `rdrive` is low during write and idle data slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline and output registers |
| hold | input | 1 | High freezes the whole core for this cycle |
| sel | input | 1 | Core select, sampled on load cycles |
| load | input | 1 | High: start a new command or deselect. Low: continue the burst |
| wr | input | 1 | Direction on load cycles: 1 write, 0 read |
| addr | input | AW (8) | Word address from the burst sequencer, used on every access cycle |
| bwe_n | input | NB (4) | Active-low write enable per 9-bit lane |
| wdata | input | W (36) | Write data, sampled two cycles after the write command |
| oe_n | input | 1 | Active-low output enable, not clocked |
| rdata | output | W (36) | Registered read data |
| rdrive | output | 1 | High when the data bus should be driven with `rdata` |

## Verification
The hardest case to produce from the ports is forwarding. It needs a read whose data cycle sits directly after a write's data cycle to the same address, with some lanes disabled, and possibly hold cycles in between. The random phase limits addresses to sixteen words and mixes loads, burst continues, deselects and holds, so these overlaps occur often. Directed sequences also place a write followed at once by a read of the same address, with partial lane enables. A bench model updates its memory in bus order, so every forwarded lane is checked against the model.

// File: rtl/lw_pkg.sv
package lw_pkg;

    // width of one independently writable lane
    localparam int LANE_W = 9;

    // burst tracker states
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_READ_BURST  = 2'd1,
        ST_WRITE_BURST = 2'd2
    } burst_st_e;

endpackage

// File: rtl/lw_burst_ctl.sv
module lw_burst_ctl
    import lw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic sel,
    input  logic load,
    input  logic wr,
    output logic issue_v,
    output logic issue_wr
);

    burst_st_e cur_st;
    burst_st_e nxt_st;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= ST_IDLE;
        end else if (step) begin
            cur_st <= nxt_st;
        end
    end

    // transitions: start_read, start_write, deselect on load; continue otherwise
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_IDLE: begin
                if (load) nxt_st = !sel ? ST_IDLE : (wr ? ST_WRITE_BURST : ST_READ_BURST);
            end
            ST_READ_BURST: begin
                if (load) nxt_st = !sel ? ST_IDLE : (wr ? ST_WRITE_BURST : ST_READ_BURST);
            end
            ST_WRITE_BURST: begin
                if (load) nxt_st = !sel ? ST_IDLE : (wr ? ST_WRITE_BURST : ST_READ_BURST);
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

    // command issued this cycle
    always_comb begin
        issue_v  = 1'b0;
        issue_wr = 1'b0;
        if (load) begin
            issue_v  = sel;
            issue_wr = wr;
        end else begin
            unique case (cur_st)
                ST_IDLE: begin
                    issue_v  = 1'b0;
                    issue_wr = 1'b0;
                end
                ST_READ_BURST: begin
                    issue_v  = 1'b1;
                    issue_wr = 1'b0;
                end
                ST_WRITE_BURST: begin
                    issue_v  = 1'b1;
                    issue_wr = 1'b1;
                end
                default: begin
                    issue_v  = 1'b0;
                    issue_wr = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lw_cmd_pipe.sv
module lw_cmd_pipe #(
    parameter int AW       = 8,
    parameter int NB       = 4,
    parameter int DATA_LAT = 2,
    localparam int STAGES  = DATA_LAT + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          in_v,
    input  logic          in_wr,
    input  logic [AW-1:0] in_addr,
    input  logic [NB-1:0] in_en,
    // command whose data slot is the coming edge
    output logic          dp_v,
    output logic          dp_wr,
    output logic [AW-1:0] dp_addr,
    // write command awaiting array commit
    output logic          cm_v,
    output logic          cm_wr,
    output logic [AW-1:0] cm_addr,
    output logic [NB-1:0] cm_en
);

    logic [STAGES-1:0]         v_q;
    logic [STAGES-1:0]         wr_q;
    logic [STAGES-1:0][AW-1:0] a_q;
    logic [STAGES-1:0][NB-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= '0;
            wr_q <= '0;
            a_q  <= '0;
            en_q <= '0;
        end else if (step) begin
            v_q[0]  <= in_v;
            wr_q[0] <= in_wr;
            a_q[0]  <= in_addr;
            en_q[0] <= in_en;
            for (int s = 1; s < STAGES; s++) begin
                v_q[s]  <= v_q[s-1];
                wr_q[s] <= wr_q[s-1];
                a_q[s]  <= a_q[s-1];
                en_q[s] <= en_q[s-1];
            end
        end
    end

    assign dp_v    = v_q[DATA_LAT-1];
    assign dp_wr   = wr_q[DATA_LAT-1];
    assign dp_addr = a_q[DATA_LAT-1];
    assign cm_v    = v_q[DATA_LAT];
    assign cm_wr   = wr_q[DATA_LAT];
    assign cm_addr = a_q[DATA_LAT];
    assign cm_en   = en_q[DATA_LAT];

endmodule

// File: rtl/lw_store.sv
module lw_store
    import lw_pkg::*;
#(
    parameter int W     = 36,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int NB   = W / LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          dp_v,
    input  logic          dp_wr,
    input  logic [AW-1:0] dp_addr,
    input  logic          cm_v,
    input  logic          cm_wr,
    input  logic [AW-1:0] cm_addr,
    input  logic [NB-1:0] cm_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata_q,
    output logic          drv_q
);

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] wd_q;
    logic [W-1:0] commit_word;
    logic [W-1:0] read_word;
    logic         commit_go;
    logic         fwd_hit;
    logic         rd_slot;

    assign commit_go = step && cm_v && cm_wr;
    assign fwd_hit   = cm_v && cm_wr && (cm_addr == dp_addr);
    assign rd_slot   = dp_v && !dp_wr;

    // input data register: captured in every active slot
    always_ff @(posedge clk) begin
        if (step) wd_q <= wdata;
    end

    // per-lane merge for commit and for forwarding
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign commit_word[b*LANE_W +: LANE_W] = cm_en[b]
            ? wd_q[b*LANE_W +: LANE_W] : mem[cm_addr][b*LANE_W +: LANE_W];
        assign read_word[b*LANE_W +: LANE_W] = (fwd_hit && cm_en[b])
            ? wd_q[b*LANE_W +: LANE_W] : mem[dp_addr][b*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (commit_go) mem[cm_addr] <= commit_word;
    end

    // output register and drive state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            drv_q   <= 1'b0;
        end else if (step) begin
            drv_q <= rd_slot;
            if (rd_slot) rdata_q <= read_word;
        end
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_pkg::*;
#(
    parameter int W     = 36,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int NB   = W / LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          sel,
    input  logic          load,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] bwe_n,
    input  logic [W-1:0]  wdata,
    input  logic          oe_n,
    output logic [W-1:0]  rdata,
    output logic          rdrive
);

    logic          step;
    logic          issue_v;
    logic          issue_wr;
    logic          dp_v;
    logic          dp_wr;
    logic [AW-1:0] dp_addr;
    logic          cm_v;
    logic          cm_wr;
    logic [AW-1:0] cm_addr;
    logic [NB-1:0] cm_en;
    logic          drv_q;

    assign step = !hold;

    lw_burst_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .sel      (sel),
        .load     (load),
        .wr       (wr),
        .issue_v  (issue_v),
        .issue_wr (issue_wr)
    );

    lw_cmd_pipe #(.AW(AW), .NB(NB), .DATA_LAT(2)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .in_v    (issue_v),
        .in_wr   (issue_wr),
        .in_addr (addr),
        .in_en   (~bwe_n),
        .dp_v    (dp_v),
        .dp_wr   (dp_wr),
        .dp_addr (dp_addr),
        .cm_v    (cm_v),
        .cm_wr   (cm_wr),
        .cm_addr (cm_addr),
        .cm_en   (cm_en)
    );

    lw_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .dp_v    (dp_v),
        .dp_wr   (dp_wr),
        .dp_addr (dp_addr),
        .cm_v    (cm_v),
        .cm_wr   (cm_wr),
        .cm_addr (cm_addr),
        .cm_en   (cm_en),
        .wdata   (wdata),
        .rdata_q (rdata),
        .drv_q   (drv_q)
    );

    assign rdrive = drv_q && !oe_n;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hold,
    input logic         sel,
    input logic         load,
    input logic         wr,
    input logic [W-1:0] rdata,
    input logic         rdrive,
    input logic         drv_q
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !rdrive);

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && load && sel && !wr) ##1 !hold ##1 !hold |=> drv_q);

    assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && load && sel && wr) ##1 !hold ##1 !hold |=> !drv_q);

    assert_deselect_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && load && !sel) ##1 !hold ##1 !hold |=> !drv_q);

    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold) && $past(rst_n)) |-> ($stable(rdata) && $stable(drv_q)));

endmodule

bind lw_sram lw_sram_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .sel    (sel),
    .load   (load),
    .wr     (wr),
    .rdata  (rdata),
    .rdrive (rdrive),
    .drv_q  (drv_q)
);

// File: tb/lw_sram_test.sv
`timescale 1ns/1ps
module lw_sram_test;

    logic        clk;
    logic        rst_n;
    logic        hold;
    logic        sel;
    logic        load;
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  bwe_n;
    logic [35:0] wdata;
    logic        oe_n;
    logic [35:0] rdata;
    logic        rdrive;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    logic [35:0] mdl [256];
    bit          bst_v, bst_wr;
    bit          h1_v, h1_wr, h2_v, h2_wr;
    logic [7:0]  h1_a, h2_a;
    logic [3:0]  h1_en, h2_en;
    logic [35:0] h1_d, h2_d;
    bit          exp_drv;
    bit          rd_seen;
    logic [35:0] exp_rd;

    lw_sram uut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sel(sel), .load(load),
        .wr(wr), .addr(addr), .bwe_n(bwe_n), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdrive(rdrive)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [35:0] lane_merge(input logic [35:0] old_w,
                                               input logic [35:0] new_w,
                                               input logic [3:0] en);
        logic [35:0] r;
        r = old_w;
        for (int b = 0; b < 4; b++)
            if (en[b]) r[b*9 +: 9] = new_w[b*9 +: 9];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock cycle of stimulus followed by the check of its result
    task automatic cyc(input bit hd, input bit sl, input bit ld, input bit w,
                       input logic [7:0] a, input logic [3:0] ben,
                       input logic [35:0] d, input string tag);
        bit nv, nwr;
        hold  = hd; sel = sl; load = ld; wr = w; addr = a; bwe_n = ben;
        wdata = (h2_v && h2_wr) ? h2_d : {$urandom, $urandom};
        @(posedge clk);
        @(negedge clk);
        if (!hd) begin
            if (h2_v && h2_wr) mdl[h2_a] = lane_merge(mdl[h2_a], h2_d, h2_en);
            exp_drv = h2_v && !h2_wr;
            if (exp_drv) begin
                exp_rd  = mdl[h2_a];
                rd_seen = 1;
            end
            if (ld) begin
                nv = sl; nwr = w; bst_v = sl; bst_wr = w;
            end else begin
                nv = bst_v; nwr = bst_wr;
            end
            h2_v = h1_v; h2_wr = h1_wr; h2_a = h1_a; h2_en = h1_en; h2_d = h1_d;
            h1_v = nv; h1_wr = nwr; h1_a = a; h1_en = ~ben; h1_d = d;
        end
        check(rdrive == (exp_drv && !oe_n), tag, {35'd0, rdrive}, {35'd0, exp_drv && !oe_n});
        if (rd_seen) check(rdata == exp_rd, tag, rdata, exp_rd);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 8'd0, 4'hF, 36'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; hold = 0; sel = 0; load = 1; wr = 0; addr = 0;
        bwe_n = 4'hF; wdata = 0; oe_n = 0;
        bst_v = 0; bst_wr = 0; h1_v = 0; h2_v = 0; h1_wr = 0; h2_wr = 0;
        h1_a = 0; h2_a = 0; h1_en = 0; h2_en = 0; h1_d = 0; h2_d = 0;
        exp_drv = 0; rd_seen = 0; exp_rd = 0;
        for (int i = 0; i < 256; i++) mdl[i] = 36'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check(rdrive == 1'b0, "R1", {35'd0, rdrive}, 36'd0);
        idle(3, "R1");

        // preload words 0..15 with one write burst (R6, R3)
        cyc(0, 1, 1, 1, 8'd0, 4'h0, {$urandom, $urandom}, "R3");
        for (int i = 1; i < 16; i++)
            cyc(0, 1, 0, 0, 8'(i), 4'h0, {$urandom, $urandom}, "R6");
        idle(3, "R7");

        // read burst back (R2), then deselect so the bus floats (R7)
        cyc(0, 1, 1, 0, 8'd0, 4'hF, 36'd0, "R2");
        for (int i = 1; i < 16; i++) cyc(0, 1, 0, 1, 8'(i), 4'h0, 36'd0, "R2");
        idle(3, "R7");

        // partial lanes: enable lanes 0 and 2 only (R4)
        cyc(0, 1, 1, 1, 8'd3, 4'b1010, 36'hA_BCDE_F012, "R4");
        idle(2, "R4");
        cyc(0, 1, 1, 0, 8'd3, 4'hF, 36'd0, "R4");
        idle(3, "R4");

        // lane enables on a read do nothing (R5)
        cyc(0, 1, 1, 0, 8'd4, 4'h0, 36'hF_FFFF_FFFF, "R5");
        cyc(0, 1, 1, 0, 8'd4, 4'hF, 36'd0, "R5");
        idle(3, "R5");

        // write then immediate read of the same word: forwarding (R10)
        cyc(0, 1, 1, 1, 8'd5, 4'b0110, 36'h1_2345_6789, "R10");
        cyc(0, 1, 1, 0, 8'd5, 4'hF, 36'd0, "R10");
        cyc(0, 1, 1, 1, 8'd6, 4'h0, 36'h9_8765_4321, "R10");
        cyc(0, 1, 1, 0, 8'd6, 4'h0, 36'd0, "R10");
        idle(3, "R10");

        // alternating direction with no gap (R11)
        for (int i = 0; i < 8; i++)
            cyc(0, 1, 1, i[0], 8'(7 + i[2:1]), 4'(i), {$urandom, $urandom}, "R11");
        idle(3, "R11");

        // hold in the middle of a read burst (R9)
        cyc(0, 1, 1, 0, 8'd1, 4'hF, 36'd0, "R9");
        cyc(1, 0, 1, 1, 8'd9, 4'h0, 36'd0, "R9");
        cyc(0, 1, 0, 0, 8'd2, 4'hF, 36'd0, "R9");
        cyc(1, 1, 1, 1, 8'd2, 4'h0, 36'd0, "R9");
        cyc(1, 0, 0, 1, 8'd2, 4'h0, 36'd0, "R9");
        cyc(0, 1, 0, 0, 8'd3, 4'hF, 36'd0, "R9");

        // output enable acts without a clock (R8)
        check(rdrive == 1'b1, "R8", {35'd0, rdrive}, 36'd1);
        oe_n = 1; #1;
        check(rdrive == 1'b0, "R8", {35'd0, rdrive}, 36'd0);
        oe_n = 0; #1;
        check(rdrive == 1'b1, "R8", {35'd0, rdrive}, 36'd1);
        idle(3, "R8");

        // after a deselect, continue cycles perform no access (R6)
        cyc(0, 1, 0, 1, 8'd10, 4'h0, 36'h0_DEAD_BEEF, "R6");
        cyc(0, 1, 0, 1, 8'd11, 4'h0, 36'h0_DEAD_BEEF, "R6");
        idle(2, "R6");
        cyc(0, 1, 1, 0, 8'd10, 4'hF, 36'd0, "R6");
        cyc(0, 1, 0, 0, 8'd11, 4'hF, 36'd0, "R6");
        idle(3, "R6");

        // constrained random traffic over 16 words
        for (int i = 0; i < 3000; i++) begin
            bit hd, ld, sl, w;
            hd = ($urandom % 10) == 0;
            ld = ($urandom % 5) < 2;
            sl = ($urandom % 8) != 0;
            w  = $urandom % 2;
            cyc(hd, sl, ld, w, 8'($urandom % 16), 4'($urandom), {$urandom, $urandom}, "R11");
        end
        idle(3, "R10");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule